// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

A shared on-chip word memory that several requesters reach through one port each. Besides plain loads and stores it runs three indivisible primitives: test-and-set, fetch-and-add and swap. Every accepted request returns the word that was in memory before the request touched it. The response is a one-cycle done pulse on the requester's own bit, and the data sits on a shared response bus.

Each requester holds `req_valid` with an opcode, a word address and an operand until it sees `req_ready` for its index. A round-robin arbiter hands out one grant per operation. An atomic operation keeps the memory for a read cycle and then a write cycle. No grant is issued in the write cycle, so no other access can land between the read and the write. Software builds locks on test-and-set or swap. A lock built from a separate load and store stays open to races.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Test-and-set (opcode 2) returns the old word and leaves the value 1 at that address.
- R2: Fetch-and-add (opcode 3) returns the old word and leaves old plus operand, wrapped modulo 2^DW, with no overflow indication.
- R3: Swap (opcode 4) returns the old word and leaves the operand at that address.
- R4: Load (opcode 0) returns the word and changes nothing. Store (opcode 1) writes the operand and returns the previous word. For both, the done pulse comes in the cycle after acceptance.
- R5: For an atomic opcode, no requester is granted and no done pulse appears in the cycle after acceptance. The done pulse comes two cycles after acceptance.
- R6: At most one `req_ready` bit is high in any cycle, and only for a requester whose `req_valid` is high.
- R7: Grants rotate. After a grant to requester i, the next grant goes to the first valid requester in the order i+1, i+2, … wrapping around.
- R8: While reset is active, `req_ready` and `rsp_done` are low. After reset every memory word reads 0.
- R9: A load followed by a store from one requester is not protected. Two requesters that each load a free lock (0) both see it free before either store lands.
- R10: Opcodes 5 to 7 act as a load: they return the word and leave memory unchanged.
- R11: At most one `rsp_done` bit is high per cycle. `rsp_data` carries the old word in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_ready | output | N_REQ | Request accepted this cycle, one-hot or zero |
| req_op | input | 3*N_REQ | Opcode per requester, requester k at bits 3k+2..3k |
| req_addr | input | AW*N_REQ | Word address per requester |
| req_data | input | DW*N_REQ | Operand per requester |
| rsp_done | output | N_REQ | One-cycle completion pulse for the owning requester |
| rsp_data | output | DW | Old memory word, valid while a done bit is high |

## Verification
The bound checker watches the handshake every cycle. It checks that grants are one-hot and only go to valid requesters, that done pulses are one-hot, that reset keeps both quiet, and that a request's done pulse comes one cycle (plain) or two cycles (atomic) after acceptance, with an idle write cycle between for atomics. The values returned, the words left in memory, the rotation order, wraparound in fetch-and-add and the load/store lock race depend on data history. Only the bench's scenarios show them, by checking every response against a reference memory model.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int N_REQ = 3,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_REQ-1:0]    req_valid,
  output logic [N_REQ-1:0]    req_ready,
  input  logic [N_REQ*3-1:0]  req_op,
  input  logic [N_REQ*AW-1:0] req_addr,
  input  logic [N_REQ*DW-1:0] req_data,
  output logic [N_REQ-1:0]    rsp_done,
  output logic [DW-1:0]       rsp_data
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_TAS   = 3'd2;
  localparam logic [2:0] OP_FAA   = 3'd3;
  localparam logic [2:0] OP_SWAP  = 3'd4;

  logic [DW-1:0] mem [DEPTH];
  logic          wr_phase;
  logic [IW-1:0] rr_ptr, gnt_idx, owner_q;
  logic          gnt_any;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opnd_q, old_q;

  always_comb begin
    logic [IW:0] cand;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N_REQ; k++) begin
      cand = {1'b0, rr_ptr} + (IW+1)'(k);
      if (cand >= (IW+1)'(N_REQ)) cand = cand - (IW+1)'(N_REQ);
      if (!gnt_any && req_valid[cand[IW-1:0]]) begin
        gnt_any = 1'b1;
        gnt_idx = cand[IW-1:0];
      end
    end
  end

  wire              accept    = gnt_any && !wr_phase && rst_n;
  wire [N_REQ-1:0]  gnt_hot   = {{(N_REQ-1){1'b0}}, 1'b1} << gnt_idx;
  wire [2:0]        sel_op    = req_op[gnt_idx*3 +: 3];
  wire [AW-1:0]     sel_addr  = req_addr[gnt_idx*AW +: AW];
  wire [DW-1:0]     sel_data  = req_data[gnt_idx*DW +: DW];
  wire              sel_atom  = (sel_op == OP_TAS) || (sel_op == OP_FAA) || (sel_op == OP_SWAP);
  wire [DW-1:0]     rd_word   = mem[sel_addr];
  wire [DW-1:0]     wb_word   = (op_q == OP_TAS) ? DW'(1) :
                                (op_q == OP_FAA) ? old_q + opnd_q : opnd_q;

  assign req_ready = accept ? gnt_hot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_phase <= 1'b0;
      rr_ptr   <= '0;
      owner_q  <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      opnd_q   <= '0;
      old_q    <= '0;
      rsp_done <= '0;
      rsp_data <= '0;
    end else begin
      rsp_done <= '0;
      if (wr_phase) begin
        mem[addr_q] <= wb_word;
        rsp_done    <= {{(N_REQ-1){1'b0}}, 1'b1} << owner_q;
        rsp_data    <= old_q;
        wr_phase    <= 1'b0;
      end else if (accept) begin
        rr_ptr <= (gnt_idx == IW'(N_REQ-1)) ? '0 : gnt_idx + 1'b1;
        if (sel_atom) begin
          wr_phase <= 1'b1;
          owner_q  <= gnt_idx;
          op_q     <= sel_op;
          addr_q   <= sel_addr;
          opnd_q   <= sel_data;
          old_q    <= rd_word;
        end else begin
          rsp_done <= gnt_hot;
          rsp_data <= rd_word;
          if (sel_op == OP_STORE) mem[sel_addr] <= sel_data;
        end
      end
    end
  end
endmodule

// File: rtl/atomic_rmw_unit_checker.sv
module atomic_rmw_unit_checker #(
  parameter int N_REQ = 3,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_REQ-1:0]    req_valid,
  input logic [N_REQ-1:0]    req_ready,
  input logic [N_REQ*3-1:0]  req_op,
  input logic [N_REQ*AW-1:0] req_addr,
  input logic [N_REQ*DW-1:0] req_data,
  input logic [N_REQ-1:0]    rsp_done,
  input logic [DW-1:0]       rsp_data
);
  logic [2:0] acc_op;
  logic       acc, acc_atomic;

  always_comb begin
    acc_op = '0;
    for (int k = 0; k < N_REQ; k++)
      if (req_ready[k]) acc_op = req_op[k*3 +: 3];
  end
  assign acc        = |req_ready;
  assign acc_atomic = acc && (acc_op >= 3'd2) && (acc_op <= 3'd4);

  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

  assert_one_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_done));

  assert_plain_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_atomic) |=> (rsp_done == $past(req_ready)));

  assert_atomic_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_atomic |=> (req_ready == '0 && rsp_done == '0));

  assert_atomic_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_atomic |=> ##1 (rsp_done == $past(req_ready, 2)));

  always @(negedge clk)
    if (!rst_n) assert_reset_quiet_R8: assert (req_ready == '0 && rsp_done == '0);
endmodule

bind atomic_rmw_unit atomic_rmw_unit_checker #(.N_REQ(N_REQ), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
  .rsp_done(rsp_done), .rsp_data(rsp_data)
);

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
  localparam int N  = 3;
  localparam int AW = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N*3-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0]    rsp_done;
  logic [DW-1:0]   rsp_data;

  atomic_rmw_unit #(.N_REQ(N), .AW(AW), .DW(DW)) i_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  typedef struct { int rq; logic [DW-1:0] val; int due; string tag; } exp_t;
  exp_t          sbq[$];
  logic [DW-1:0] model [1<<AW];
  int            cyc = 0, n_chk = 0, n_fail = 0;
  int            grant_log[$];
  int            rsp_seen [N];
  logic [DW-1:0] first_rsp[N];
  bit            done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(int r, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    exp_t e;
    @(negedge clk);
    req_op[r*3 +: 3]    = op;
    req_addr[r*AW +: AW] = a;
    req_data[r*DW +: DW] = d;
    req_valid[r]        = 1'b1;
    #1;
    while (!req_ready[r]) begin @(negedge clk); #1; end
    e.rq = r; e.val = model[a]; e.tag = tag;
    e.due = cyc + ((op >= 3'd2 && op <= 3'd4) ? 2 : 1);
    sbq.push_back(e);
    grant_log.push_back(r);
    case (op)
      3'd1, 3'd4: model[a] = d;
      3'd2:       model[a] = DW'(1);
      3'd3:       model[a] = model[a] + d;
      default:    ;
    endcase
    @(posedge clk); #1;
    req_valid[r] = 1'b0;
  endtask

  task automatic clear_log();
    grant_log.delete();
    for (int i = 0; i < N; i++) rsp_seen[i] = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_done != '0) begin
      if (sbq.size() == 0) begin
        check(0, "R11 unexpected done", rsp_done, 0);
      end else begin
        exp_t e;
        logic [N-1:0] hot;
        e = sbq.pop_front();
        hot = N'(1) << e.rq;
        check(rsp_done == hot, {e.tag, " requester"}, rsp_done, hot);
        check(rsp_data == e.val, {e.tag, " old value"}, rsp_data, e.val);
        check(cyc == e.due, {e.tag, " latency"}, cyc, e.due);
        for (int i = 0; i < N; i++)
          if (rsp_done[i]) begin
            if (rsp_seen[i] == 0) first_rsp[i] = rsp_data;
            rsp_seen[i]++;
          end
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) model[i] = '0;
    clear_log();
    req_valid = '1;
    repeat (3) @(negedge clk);
    check(req_ready == '0 && rsp_done == '0, "R8 quiet in reset", {req_ready, rsp_done}, 0);
    req_valid = '0;
    @(negedge clk); rst_n = 1'b1;

    issue(0, 3'd0, 4'd3, '0, "R8 cleared memory");
    issue(0, 3'd1, 4'd3, 16'h1234, "R4 store");
    issue(1, 3'd0, 4'd3, '0, "R4 load");
    issue(2, 3'd2, 4'd3, 16'hBEEF, "R1 tas free");
    issue(1, 3'd0, 4'd3, '0, "R1 tas wrote one");
    issue(0, 3'd2, 4'd3, '0, "R1 tas held");
    issue(0, 3'd1, 4'd7, 16'hFFF0, "R4 store");
    issue(1, 3'd3, 4'd7, 16'h0020, "R2 faa wrap");
    issue(2, 3'd3, 4'd7, 16'h0005, "R2 faa after wrap");
    issue(2, 3'd0, 4'd7, '0, "R2 faa sum");
    issue(1, 3'd4, 4'd7, 16'hA5A5, "R3 swap");
    issue(0, 3'd0, 4'd7, '0, "R3 swap wrote operand");
    issue(0, 3'd7, 4'd7, 16'h0000, "R10 opcode 7");
    issue(1, 3'd5, 4'd7, 16'h1111, "R10 opcode 5");
    issue(2, 3'd0, 4'd7, '0, "R10 memory unchanged");

    issue(0, 3'd0, 4'd0, '0, "R7 prime");
    clear_log();
    fork
      issue(0, 3'd0, 4'd1, '0, "R7 rotate");
      issue(1, 3'd0, 4'd2, '0, "R7 rotate");
      issue(2, 3'd0, 4'd3, '0, "R7 rotate");
    join
    check(grant_log.size() == 3 && grant_log[0] == 1 && grant_log[1] == 2 && grant_log[2] == 0,
          "R7 order 1,2,0", grant_log.size() == 3 ? grant_log[0]*100 + grant_log[1]*10 + grant_log[2] : -1, 120);
    clear_log();
    fork
      issue(2, 3'd0, 4'd1, '0, "R7 skip");
      issue(0, 3'd0, 4'd2, '0, "R7 skip");
    join
    check(grant_log.size() == 2 && grant_log[0] == 2 && grant_log[1] == 0,
          "R7 order 2,0", grant_log.size() == 2 ? grant_log[0]*10 + grant_log[1] : -1, 20);

    repeat (3) @(negedge clk);
    clear_log();
    fork
      issue(0, 3'd2, 4'd9, '0, "R5 contended tas");
      issue(1, 3'd2, 4'd9, '0, "R5 contended tas");
      issue(2, 3'd3, 4'd9, 16'd3, "R5 contended faa");
    join
    repeat (3) @(negedge clk);
    check(((first_rsp[0] == 0) ? 1 : 0) + ((first_rsp[1] == 0) ? 1 : 0) == 1,
          "R5 one tas winner", {first_rsp[0], first_rsp[1]}, 1);
    issue(0, 3'd0, 4'd9, '0, "R2 faa on held lock");

    repeat (3) @(negedge clk);
    clear_log();
    fork
      begin issue(0, 3'd0, 4'd10, '0, "R9 load"); issue(0, 3'd1, 4'd10, 16'd1, "R9 store"); end
      begin issue(1, 3'd0, 4'd10, '0, "R9 load"); issue(1, 3'd1, 4'd10, 16'd1, "R9 store"); end
    join
    repeat (3) @(negedge clk);
    check(first_rsp[0] == 0 && first_rsp[1] == 0, "R9 both saw free lock",
          {first_rsp[0], first_rsp[1]}, 0);

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R11 all responses seen", sbq.size(), 0);
    finish_run();
  end
endmodule